// File: doc/BRIEF.md
# Serial Management Register Slave for a 10/100 Ethernet PHY

This block is the management end of a two-wire serial link. The management master drives a clock (MDC) and shares one data line (MDIO) with the block. Each frame either reads or writes one of six 16-bit registers. These registers hold the PHY's control word, its live status, two identifier words, its advertised abilities and the abilities reported by the link partner. The block decodes each frame one bit per rising MDC edge. It compares the frame's PHY address with its own address, then either updates a writable register or returns a register's contents serially. It drives the shared line only during the window in which it returns data.

The block clocks itself from MDC. Its asynchronous active-low reset is released in step with MDC. The block has no fixed address input. While reset is active, it samples the levels on four strap pins on every MDC edge. It keeps the last value sampled before reset ends as the low four bits of its 5-bit address. The top bit of the address is always zero. Strap changes after reset are ignored. MDC must toggle during reset so that the straps are captured. Any frame that breaks the format, or that carries another PHY's address, sends the decoder back to searching for a preamble without touching the line or the registers.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: The register addresses are as follows. Address 0 is the control word (read/write). Address 1 returns `stat_i`. Address 2 returns the constant ID_HI. Address 3 returns the constant ID_LO. Address 4 is the advertisement word (read/write). Address 5 returns `lp_i`.
- R2: A frame is sampled on rising MDC edges as follows: at least 32 ones, start bits 0 then 1, a 2-bit opcode (1,0 = read; 0,1 = write), a 5-bit PHY address MSB first, a 5-bit register address MSB first, two turnaround bits, then 16 data bits MSB first. A preamble longer than 32 ones is accepted.
- R3: A read frame is timed as follows. `mdio_oe` stays low through the first turnaround bit. `mdio_oe` rises with `mdio_o`=0 for the second turnaround bit. The 16 data bits follow MSB first, each updated just after a rising MDC edge. `mdio_oe` falls after the last data bit, so the block drives for exactly 17 bit periods.
- R4: A write frame updates a read/write register at the rising edge that samples the last data bit. The new value appears on `ctrl_o` (address 0) or `adv_o` (address 4) and is returned by later reads. On a write, the turnaround bits must be 1 then 0.
- R5: The PHY address is {1'b0, strap_i} as sampled while reset is asserted. Changing `strap_i` after reset does not change which address the block answers to.
- R6: A frame whose PHY address differs from the block's own address produces no drive on MDIO and no register update.
- R7: A read of register addresses 6 to 31 returns 0x0000, and a write to them changes no register.
- R8: Writes to addresses 1, 2, 3 and 5 have no effect. `ctrl_o`, `adv_o` and later reads of those addresses are unchanged.
- R9: The following frames make the block wait for a fresh preamble of at least 32 ones, with no drive and no write: a preamble shorter than 32 ones, a bad start pair, an opcode of 00 or 11, or write turnaround bits other than 1,0.
- R10: After reset, `mdio_oe` is low, `ctrl_o` equals CTRL_RST and `adv_o` equals ADV_RST.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all sampling and driving happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | STRAP_W (4) | Strap levels captured as the low address bits during reset |
| mdio_i | input | 1 | Data line as seen by the block |
| mdio_o | output | 1 | Data value driven when `mdio_oe` is high |
| mdio_oe | output | 1 | Output enable for the shared data line |
| stat_i | input | DW (16) | Live status word returned at address 1 |
| lp_i | input | DW (16) | Link-partner ability word returned at address 5 |
| ctrl_o | output | DW (16) | Current control word (address 0) |
| adv_o | output | DW (16) | Current advertisement word (address 4) |

## Verification
The bench builds the block with its default parameters: a 4-bit strap, a 5-bit PHY and register address, a 32-bit minimum preamble and 16-bit registers. It straps 1010 during reset and then moves the straps to 0101. This makes address 10 live and lets the bench show two cases: the post-reset strap value (5) is ignored, and an address that differs only in the zero top bit (26) is ignored. With the 5-bit register address, the bench can reach unimplemented addresses above the six real registers, up to 31. With the 32-bit minimum, a 31-one preamble is a reachable near miss and a 40-one preamble tests the saturating count.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  typedef enum logic [3:0] {
    S_PRE,
    S_ST,
    S_OP,
    S_PHY,
    S_REG,
    S_TA_RD,
    S_RD,
    S_TA_WR,
    S_WR
  } mdio_state_e;

  localparam int REG_CTRL  = 0;
  localparam int REG_STAT  = 1;
  localparam int REG_ID_HI = 2;
  localparam int REG_ID_LO = 3;
  localparam int REG_ADV   = 4;
  localparam int REG_LP    = 5;

endpackage

// File: rtl/mdio_rst_strap.sv
module mdio_rst_strap #(
  parameter int STRAP_W = 4,
  parameter int PHY_AW  = 5
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               rst_sync_no,
  output logic [PHY_AW-1:0]  own_addr_o
);

  logic [1:0]         sync_q;
  logic [STRAP_W-1:0] strap_q;

  // reset asserts at once, releases after two MDC edges
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];

  // strap capture: enabled only while internal reset is active
  always_ff @(posedge clk) begin
    if (!sync_q[1]) strap_q <= strap_i;
  end

  generate
    if (STRAP_W < PHY_AW) begin : g_pad
      assign own_addr_o = {{(PHY_AW-STRAP_W){1'b0}}, strap_q};
    end else begin : g_trim
      assign own_addr_o = strap_q[PHY_AW-1:0];
    end
  endgenerate

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int PHY_AW  = 5,
  parameter int REG_AW  = 5,
  parameter int DW      = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              mdio_i,
  input  logic [PHY_AW-1:0] own_addr_i,
  input  logic [DW-1:0]     rd_data_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [PHY_AW-1:0] phy_addr_o,
  output logic              wr_en_o,
  output logic [DW-1:0]     wr_data_o
);

  localparam int PCW = $clog2(PRE_LEN + 1);
  localparam int CW  = $clog2(DW + 1);
  localparam logic [PCW-1:0] PRE_MAX  = PCW'(PRE_LEN);
  localparam logic [CW-1:0]  PHY_LAST = CW'(PHY_AW - 1);
  localparam logic [CW-1:0]  REG_LAST = CW'(REG_AW - 1);
  localparam logic [CW-1:0]  DAT_LAST = CW'(DW - 1);
  localparam logic [CW-1:0]  DAT_END  = CW'(DW);

  mdio_state_e       state_q, state_d;
  logic [PCW-1:0]    pre_q, pre_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              rd_q, rd_d;
  logic [PHY_AW-1:0] phy_q, phy_d;
  logic [REG_AW-1:0] reg_q, reg_d;
  logic [DW-1:0]     sh_q, sh_d;
  logic              o_q, o_d;
  logic              oe_q, oe_d;

  always_comb begin
    state_d = state_q;
    pre_d   = pre_q;
    cnt_d   = cnt_q;
    rd_d    = rd_q;
    phy_d   = phy_q;
    reg_d   = reg_q;
    sh_d    = sh_q;
    o_d     = o_q;
    oe_d    = oe_q;
    wr_en_o = 1'b0;
    unique case (state_q)
      S_PRE: begin
        if (mdio_i) begin
          if (pre_q < PRE_MAX) pre_d = pre_q + 1'b1;
        end else if (pre_q == PRE_MAX) begin
          state_d = S_ST;
        end else begin
          pre_d = '0;
        end
      end
      S_ST: begin
        if (mdio_i) begin
          state_d = S_OP;
          cnt_d   = '0;
        end else begin
          state_d = S_PRE;
          pre_d   = '0;
        end
      end
      S_OP: begin
        if (cnt_q == '0) begin
          rd_d  = mdio_i;
          cnt_d = CW'(1);
        end else if (rd_q != mdio_i) begin
          state_d = S_PHY;
          cnt_d   = '0;
        end else begin
          state_d = S_PRE;
          pre_d   = '0;
        end
      end
      S_PHY: begin
        phy_d = {phy_q[PHY_AW-2:0], mdio_i};
        if (cnt_q == PHY_LAST) begin
          state_d = S_REG;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_REG: begin
        reg_d = {reg_q[REG_AW-2:0], mdio_i};
        if (cnt_q != REG_LAST) begin
          cnt_d = cnt_q + 1'b1;
        end else if (phy_q != own_addr_i) begin
          state_d = S_PRE;
          pre_d   = '0;
        end else begin
          state_d = rd_q ? S_TA_RD : S_TA_WR;
          cnt_d   = '0;
        end
      end
      S_TA_RD: begin
        sh_d    = rd_data_i;
        oe_d    = 1'b1;
        o_d     = 1'b0;
        state_d = S_RD;
        cnt_d   = '0;
      end
      S_RD: begin
        if (cnt_q == DAT_END) begin
          oe_d    = 1'b0;
          o_d     = 1'b0;
          state_d = S_PRE;
          pre_d   = '0;
        end else begin
          o_d   = sh_q[DW-1];
          sh_d  = {sh_q[DW-2:0], 1'b0};
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_TA_WR: begin
        if (cnt_q == '0 && mdio_i) begin
          cnt_d = CW'(1);
        end else if (cnt_q != '0 && !mdio_i) begin
          state_d = S_WR;
          cnt_d   = '0;
        end else begin
          state_d = S_PRE;
          pre_d   = '0;
        end
      end
      S_WR: begin
        sh_d = {sh_q[DW-2:0], mdio_i};
        if (cnt_q == DAT_LAST) begin
          wr_en_o = 1'b1;
          state_d = S_PRE;
          pre_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = S_PRE;
        pre_d   = '0;
        oe_d    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_PRE;
      pre_q   <= '0;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      sh_q    <= '0;
      o_q     <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pre_q   <= pre_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
      phy_q   <= phy_d;
      reg_q   <= reg_d;
      sh_q    <= sh_d;
      o_q     <= o_d;
      oe_q    <= oe_d;
    end
  end

  assign mdio_o     = o_q;
  assign mdio_oe_o  = oe_q;
  assign reg_addr_o = reg_q;
  assign phy_addr_o = phy_q;
  assign wr_data_o  = {sh_q[DW-2:0], mdio_i};

endmodule

// File: rtl/mdio_regbank.sv
module mdio_regbank
  import mdio_mgmt_pkg::*;
#(
  parameter int          REG_AW   = 5,
  parameter int          DW       = 16,
  parameter logic [15:0] CTRL_RST = 16'h3000,
  parameter logic [15:0] ADV_RST  = 16'h01E1,
  parameter logic [15:0] ID_HI    = 16'h2A41,
  parameter logic [15:0] ID_LO    = 16'h5C07
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [DW-1:0]     stat_i,
  input  logic [DW-1:0]     lp_i,
  output logic [DW-1:0]     rd_data_o,
  output logic [DW-1:0]     ctrl_o,
  output logic [DW-1:0]     adv_o
);

  localparam int NRW = 2;
  localparam logic [NRW-1:0][REG_AW-1:0] RW_ADDR = {REG_AW'(REG_ADV), REG_AW'(REG_CTRL)};
  localparam logic [NRW-1:0][DW-1:0]     RW_RST  = {DW'(ADV_RST), DW'(CTRL_RST)};

  logic [NRW-1:0][DW-1:0] rw_w;

  for (genvar g = 0; g < NRW; g++) begin : g_rw
    logic          we;
    logic [DW-1:0] q;
    assign we = wr_en_i && (addr_i == RW_ADDR[g]);
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  q <= RW_RST[g];
      else if (we)  q <= wr_data_i;
    end
    assign rw_w[g] = q;
  end

  assign ctrl_o = rw_w[0];
  assign adv_o  = rw_w[1];

  always_comb begin
    unique case (addr_i)
      REG_AW'(REG_CTRL):  rd_data_o = rw_w[0];
      REG_AW'(REG_STAT):  rd_data_o = stat_i;
      REG_AW'(REG_ID_HI): rd_data_o = DW'(ID_HI);
      REG_AW'(REG_ID_LO): rd_data_o = DW'(ID_LO);
      REG_AW'(REG_ADV):   rd_data_o = rw_w[1];
      REG_AW'(REG_LP):    rd_data_o = lp_i;
      default:            rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int          STRAP_W  = 4,
  parameter int          PHY_AW   = 5,
  parameter int          REG_AW   = 5,
  parameter int          DW       = 16,
  parameter int          PRE_LEN  = 32,
  parameter logic [15:0] CTRL_RST = 16'h3000,
  parameter logic [15:0] ADV_RST  = 16'h01E1,
  parameter logic [15:0] ID_HI    = 16'h2A41,
  parameter logic [15:0] ID_LO    = 16'h5C07
) (
  input  logic               mdc,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic [DW-1:0]      stat_i,
  input  logic [DW-1:0]      lp_i,
  output logic [DW-1:0]      ctrl_o,
  output logic [DW-1:0]      adv_o
);

  logic              rst_sync_n;
  logic [PHY_AW-1:0] own_addr;
  logic [PHY_AW-1:0] frame_phy;
  logic [REG_AW-1:0] reg_addr;
  logic              wr_en;
  logic [DW-1:0]     wr_data;
  logic [DW-1:0]     rd_data;

  mdio_rst_strap #(
    .STRAP_W (STRAP_W),
    .PHY_AW  (PHY_AW)
  ) u_strap (
    .clk         (mdc),
    .rst_ni      (rst_n),
    .strap_i     (strap_i),
    .rst_sync_no (rst_sync_n),
    .own_addr_o  (own_addr)
  );

  mdio_frame_fsm #(
    .PRE_LEN (PRE_LEN),
    .PHY_AW  (PHY_AW),
    .REG_AW  (REG_AW),
    .DW      (DW)
  ) u_fsm (
    .clk        (mdc),
    .rst_ni     (rst_sync_n),
    .mdio_i     (mdio_i),
    .own_addr_i (own_addr),
    .rd_data_i  (rd_data),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe),
    .reg_addr_o (reg_addr),
    .phy_addr_o (frame_phy),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data)
  );

  mdio_regbank #(
    .REG_AW   (REG_AW),
    .DW       (DW),
    .CTRL_RST (CTRL_RST),
    .ADV_RST  (ADV_RST),
    .ID_HI    (ID_HI),
    .ID_LO    (ID_LO)
  ) u_regs (
    .clk       (mdc),
    .rst_ni    (rst_sync_n),
    .wr_en_i   (wr_en),
    .addr_i    (reg_addr),
    .wr_data_i (wr_data),
    .stat_i    (stat_i),
    .lp_i      (lp_i),
    .rd_data_o (rd_data),
    .ctrl_o    (ctrl_o),
    .adv_o     (adv_o)
  );

endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk #(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DW     = 16
) (
  input logic              mdc,
  input logic              rst_n,
  input logic              rst_sync_n,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              wr_en,
  input logic [REG_AW-1:0] wr_addr,
  input logic [PHY_AW-1:0] frame_phy,
  input logic [PHY_AW-1:0] own_addr,
  input logic [DW-1:0]     ctrl_o,
  input logic [DW-1:0]     adv_o
);

  localparam int RCW = $clog2(DW + 3);
  localparam logic [RCW-1:0] RUN_MAX = RCW'(DW + 1);

  logic [RCW-1:0] oe_run;
  logic           armed;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n)                          oe_run <= '0;
    else if (!mdio_oe)                   oe_run <= '0;
    else if (oe_run <= RUN_MAX)          oe_run <= oe_run + 1'b1;
  end

  always_ff @(posedge mdc or negedge rst_sync_n) begin
    if (!rst_sync_n) armed <= 1'b0;
    else             armed <= 1'b1;
  end

  AST_TA_DRIVES_ZERO: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);                                           // R3
  AST_DRIVE_WINDOW: assert property (@(posedge mdc) disable iff (!rst_n)
    oe_run <= RUN_MAX);                                                    // R3
  AST_WRITE_OWN_ADDR: assert property (@(posedge mdc) disable iff (!rst_n)
    wr_en |-> (frame_phy == own_addr));                                    // R6
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge mdc) disable iff (!rst_n)
    !(mdio_oe && wr_en));                                                  // R2
  AST_CTRL_HOLD: assert property (@(posedge mdc) disable iff (!rst_n)
    !(wr_en && wr_addr == REG_AW'(0)) |=> $stable(ctrl_o));                // R8
  AST_ADV_HOLD: assert property (@(posedge mdc) disable iff (!rst_n)
    !(wr_en && wr_addr == REG_AW'(4)) |=> $stable(adv_o));                 // R7
  AST_ADDR_FROZEN: assert property (@(posedge mdc) disable iff (!rst_sync_n)
    armed |-> $stable(own_addr));                                          // R5

endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(
  .PHY_AW (PHY_AW),
  .REG_AW (REG_AW),
  .DW     (DW)
) u_chk (
  .mdc        (mdc),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .wr_en      (wr_en),
  .wr_addr    (reg_addr),
  .frame_phy  (frame_phy),
  .own_addr   (own_addr),
  .ctrl_o     (ctrl_o),
  .adv_o      (adv_o)
);

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb;

  localparam logic [15:0] CTRL_RST = 16'h3000;
  localparam logic [15:0] ADV_RST  = 16'h01E1;
  localparam logic [15:0] ID_HI    = 16'h2A41;
  localparam logic [15:0] ID_LO    = 16'h5C07;

  logic        mdc;
  logic        rst_n;
  logic [3:0]  strap_i;
  logic        mdio_i;
  logic        mdio_o;
  logic        mdio_oe;
  logic [15:0] stat_i;
  logic [15:0] lp_i;
  logic [15:0] ctrl_o;
  logic [15:0] adv_o;

  int errs   = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  typedef struct packed {
    logic        bit_v;
    logic        exp_oe;
    logic        exp_o;
    logic        do_wr;
    logic [4:0]  wr_a;
    logic [15:0] wr_d;
    logic [3:0]  req;
  } ent_t;

  ent_t q[$];

  // reference state
  logic [15:0] m_ctrl;
  logic [15:0] m_adv;
  logic [4:0]  m_addr;

  mdio_mgmt_slave u_dut (
    .mdc     (mdc),
    .rst_n   (rst_n),
    .strap_i (strap_i),
    .mdio_i  (mdio_i),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .stat_i  (stat_i),
    .lp_i    (lp_i),
    .ctrl_o  (ctrl_o),
    .adv_o   (adv_o)
  );

  initial mdc = 1'b0;
  always #4 mdc = ~mdc;

  always @(posedge mdc) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [4:0] ra);
    case (ra)
      5'd0:    return m_ctrl;
      5'd1:    return stat_i;
      5'd2:    return ID_HI;
      5'd3:    return ID_LO;
      5'd4:    return m_adv;
      5'd5:    return lp_i;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic push(input logic b, input logic oe, input logic o, input int req,
                      input logic wr = 1'b0, input logic [4:0] a = '0, input logic [15:0] d = '0);
    ent_t e;
    e.bit_v = b; e.exp_oe = oe; e.exp_o = o; e.do_wr = wr;
    e.wr_a = a; e.wr_d = d; e.req = 4'(req);
    q.push_back(e);
  endtask

  task automatic run_queue();
    while (q.size() > 0) begin
      ent_t e = q.pop_front();
      @(negedge mdc);
      chk(int'(e.req), "mdio_oe", {15'd0, mdio_oe}, {15'd0, e.exp_oe});
      if (e.exp_oe) chk(int'(e.req), "mdio_o", {15'd0, mdio_o}, {15'd0, e.exp_o});
      chk(int'(e.req), "ctrl_o", ctrl_o, m_ctrl);
      chk(int'(e.req), "adv_o", adv_o, m_adv);
      mdio_i = e.bit_v;
      @(posedge mdc);
      if (e.do_wr) begin
        if (e.wr_a == 5'd0) m_ctrl = e.wr_d;
        if (e.wr_a == 5'd4) m_adv  = e.wr_d;
      end
    end
  endtask

  // one frame: reference decides when the block must answer
  task automatic frame(input int pre_n, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] ra, input logic [1:0] ta,
                       input logic [15:0] data, input int req);
    bit ok_hdr = (pre_n >= 32) && (st == 2'b01) && (phy == m_addr);
    bit is_rd  = ok_hdr && (op == 2'b10);
    bit is_wr  = ok_hdr && (op == 2'b01) && (ta == 2'b10);
    logic [15:0] rv = model_read(ra);
    for (int i = 0; i < pre_n; i++) push(1'b1, 1'b0, 1'b0, req);
    for (int i = 1; i >= 0; i--) push(st[i], 1'b0, 1'b0, req);
    for (int i = 1; i >= 0; i--) push(op[i], 1'b0, 1'b0, req);
    for (int i = 4; i >= 0; i--) push(phy[i], 1'b0, 1'b0, req);
    for (int i = 4; i >= 0; i--) push(ra[i], 1'b0, 1'b0, req);
    if (is_rd) begin
      push(1'b1, 1'b0, 1'b0, req);
      push(1'b1, 1'b1, 1'b0, req);
      for (int i = 15; i >= 0; i--) push(1'b1, 1'b1, rv[i], req);
    end else if (op == 2'b10) begin
      for (int i = 0; i < 18; i++) push(1'b1, 1'b0, 1'b0, req);
    end else begin
      for (int i = 1; i >= 0; i--) push(ta[i], 1'b0, 1'b0, req);
      for (int i = 15; i >= 0; i--)
        push(data[i], 1'b0, 1'b0, req, (i == 0) && is_wr, ra, data);
    end
    push(1'b1, 1'b0, 1'b0, req);
    run_queue();
  endtask

  task automatic rd(input logic [4:0] phy, input logic [4:0] ra, input int req);
    frame(32, 2'b01, 2'b10, phy, ra, 2'b10, 16'h0000, req);
  endtask

  task automatic wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d, input int req);
    frame(32, 2'b01, 2'b01, phy, ra, 2'b10, d, req);
  endtask

  initial begin
    rst_n   = 1'b0;
    strap_i = 4'b1010;
    mdio_i  = 1'b1;
    stat_i  = 16'h7849;
    lp_i    = 16'h45E1;
    m_ctrl  = CTRL_RST;
    m_adv   = ADV_RST;
    m_addr  = 5'd10;
    repeat (6) @(posedge mdc);
    @(negedge mdc) rst_n = 1'b1;
    repeat (4) @(posedge mdc);
    @(negedge mdc) strap_i = 4'b0101; // R5: late strap change must not move the address

    // R10: reset state
    chk(10, "reset mdio_oe", {15'd0, mdio_oe}, 16'd0);
    chk(10, "reset ctrl_o", ctrl_o, CTRL_RST);
    chk(10, "reset adv_o", adv_o, ADV_RST);

    // R1 / R2 / R3: read every implemented register
    for (int a = 0; a < 6; a++) rd(5'd10, 5'(a), 1);

    // R4: writes to the two writable words, then read back
    wr(5'd10, 5'd0, 16'hA5C3, 4);
    rd(5'd10, 5'd0, 4);
    wr(5'd10, 5'd4, 16'h0C21, 4);
    rd(5'd10, 5'd4, 4);

    // R8: writes to read-only addresses do nothing
    wr(5'd10, 5'd1, 16'hFFFF, 8);
    wr(5'd10, 5'd2, 16'hFFFF, 8);
    wr(5'd10, 5'd3, 16'h0000, 8);
    wr(5'd10, 5'd5, 16'hFFFF, 8);
    rd(5'd10, 5'd2, 8);
    rd(5'd10, 5'd3, 8);

    // R7: unimplemented addresses
    wr(5'd10, 5'd6, 16'h1234, 7);
    wr(5'd10, 5'd31, 16'hBEEF, 7);
    rd(5'd10, 5'd6, 7);
    rd(5'd10, 5'd17, 7);
    rd(5'd10, 5'd31, 7);

    // R6 and R5: other addresses are ignored
    rd(5'd5, 5'd0, 5);
    rd(5'd26, 5'd0, 6);
    wr(5'd5, 5'd0, 16'h0F0F, 5);
    wr(5'd26, 5'd4, 16'hF0F0, 6);
    rd(5'd10, 5'd0, 6);

    // R9: malformed frames, each preceded by a zero so no idle ones count
    push(1'b0, 1'b0, 1'b0, 9);
    frame(31, 2'b01, 2'b10, 5'd10, 5'd0, 2'b10, 16'h0, 9);
    frame(32, 2'b00, 2'b10, 5'd10, 5'd0, 2'b10, 16'h0, 9);
    frame(32, 2'b01, 2'b11, 5'd10, 5'd0, 2'b10, 16'h0, 9);
    frame(32, 2'b01, 2'b00, 5'd10, 5'd0, 2'b10, 16'h0, 9);
    frame(32, 2'b01, 2'b01, 5'd10, 5'd0, 2'b00, 16'h5555, 9);
    push(1'b0, 1'b0, 1'b0, 9);
    frame(31, 2'b01, 2'b01, 5'd10, 5'd4, 2'b10, 16'h7777, 9);
    rd(5'd10, 5'd0, 9);

    // R2: long preamble is accepted
    frame(40, 2'b01, 2'b10, 5'd10, 5'd4, 2'b10, 16'h0, 2);

    // R1: status and partner words follow their inputs
    stat_i = 16'h0123;
    lp_i   = 16'hFEDC;
    rd(5'd10, 5'd1, 1);
    rd(5'd10, 5'd5, 1);

    // R4: a second write to control
    wr(5'd10, 5'd0, 16'h8001, 4);
    rd(5'd10, 5'd0, 4);
    chk(4, "final ctrl_o", ctrl_o, 16'h8001);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule